// File: doc/BRIEF.md
# Millisecond Periodic Interrupt Timer

This block raises a periodic interrupt at an interval programmed in whole milliseconds. A prescaler divides the fast reference clock down to a one-millisecond tick. A millisecond counter advances on each tick and is compared with a period register. When the count reaches the period, the counter returns to zero on that same tick and a sticky event flag is raised. The interrupt line is the event flag gated by an interrupt enable.

Software reaches three registers over a plain single-cycle memory-mapped bus. A status word holds the count enable, the interrupt enable and the write-one-to-clear event flag. A period register holds the interval. A read-only count register shows the current count. Writes take effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. There is no handshake: every access completes in the cycle it is presented.

Top module: `ms_periodic_timer`

## Requirements
- R1: After reset, the status word, count and period all read as zero and `irq` is low.
- R2: While the count enable (status bit 15) is 1, the count advances by one every `CLKS_PER_MS` clock cycles. The first advance comes `CLKS_PER_MS` cycles after the enable is written.
- R3: On the tick where count+1 would equal the period, the count becomes 0 and the event flag (status bit 13) becomes 1 at the same edge. Events are therefore exactly period × `CLKS_PER_MS` cycles apart.
- R4: Writing the count enable to 0 clears the count and the prescaler at the next edge. A later re-enable gives a full first period.
- R5: A period of 0 never sets the event flag, and the count stays at 0.
- R6: Writing 1 to status bit 13 clears the event flag, and writing 0 there leaves it unchanged. An event in the same cycle as a clear wins. Bits 15 and 14 take the written value.
- R7: `irq` is 1 exactly when the event flag and the interrupt enable (status bit 14) are both 1.
- R8: The count register at offset 0x34 is read-only, and a write to it changes nothing.
- R9: If the period is lowered to a value not above the current count, the next tick returns the count to 0 and sets the flag.
- R10: The read map places the status word at 0x08, with only bits 15..13 nonzero. The count sits at 0x34 and the period at 0x38 (low `PERIOD_W` bits). Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Periodic interrupt request, level |

## Verification
A prescaler that drifts or is not cleared on disable shows up at the count register as a late or early increment. It is visible within one millisecond tick of the fault. A wrong compare or reload shows as a count that passes the period, or as a flag that rises on the wrong edge. An event lost against a clear leaves the flag low a full period longer than it should be. The bench reads back one register every cycle and compares `irq` every cycle against a behavioural model, so any such divergence is reported in the cycle it first reaches a port.

// File: rtl/ms_timer_pkg.sv
package ms_timer_pkg;
  localparam int OFS_STATUS = 'h08;
  localparam int OFS_COUNT  = 'h34;
  localparam int OFS_PERIOD = 'h38;

  localparam int BIT_RUN    = 15;
  localparam int BIT_IEN    = 14;
  localparam int BIT_EVT    = 13;

  typedef struct packed {
    logic run;
    logic ien;
    logic evt;
  } ctrl_t;
endpackage

// File: rtl/ms_prescaler.sv
module ms_prescaler #(
  parameter int CLKS_PER_MS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (CLKS_PER_MS <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      localparam int PW = $clog2(CLKS_PER_MS);
      localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          phase_q <= '0;
        else if (!run)       phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                 phase_q <= phase_q + 1'b1;
      end

      assign tick = run && (phase_q == LAST);

      // R4: an idle prescaler restarts from phase zero
      a_r4_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase_q == '0));
      // R2: ticks never come on back-to-back cycles
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ms_count_unit.sv
module ms_count_unit #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             event_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W:0]   next_val;
  logic             reach;

  assign next_val = {1'b0, count_q} + 1'b1;
  assign reach    = (period != '0) && (next_val >= {1'b0, period});
  assign event_o  = run && tick && reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 count_q <= '0;
    else if (!run)              count_q <= '0;
    else if (tick) begin
      if (period == '0 || reach) count_q <= '0;
      else                       count_q <= next_val[CNT_W-1:0];
    end
  end

  assign count = count_q;

  // R2: the count only steps by one or returns to zero
  a_r2_step_or_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |-> ((count_q == $past(count_q) + 1'b1) || (count_q == '0)));
  // R5: a zero period produces no event
  a_r5_zero_period_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> !event_o);
  // R3: an event leaves the count at zero
  a_r3_event_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> (count_q == '0));
endmodule

// File: rtl/ms_status_unit.sv
module ms_status_unit
  import ms_timer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_status,
  input  logic  wr_run,
  input  logic  wr_ien,
  input  logic  wr_evt_clr,
  input  logic  event_i,
  output ctrl_t ctrl,
  output logic  irq
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_status) begin
        ctrl_q.run <= wr_run;
        ctrl_q.ien <= wr_ien;
      end
      if (event_i)                      ctrl_q.evt <= 1'b1;
      else if (wr_status && wr_evt_clr) ctrl_q.evt <= 1'b0;
    end
  end

  assign ctrl = ctrl_q;
  assign irq  = ctrl_q.evt & ctrl_q.ien;

  // R7: the line is never high without its enable
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q.ien);
  // R6: an event is always recorded, even against a clear
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |=> ctrl_q.evt);
  // R6: a clear with no competing event empties the flag
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && wr_evt_clr && !event_i) |=> !ctrl_q.evt);
endmodule

// File: rtl/ms_periodic_timer.sv
module ms_periodic_timer
  import ms_timer_pkg::*;
#(
  parameter int CLKS_PER_MS = 100000,
  parameter int PERIOD_W    = 10,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFS_PERIOD);

  logic                tick;
  logic                evt;
  logic [PERIOD_W-1:0] period_q;
  logic [PERIOD_W-1:0] count;
  ctrl_t               ctrl;
  logic                wr_status;

  assign wr_status = bus_wr && (bus_addr == A_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               period_q <= '0;
    else if (bus_wr && bus_addr == A_PERIOD)  period_q <= bus_wdata[PERIOD_W-1:0];
  end

  ms_prescaler #(.CLKS_PER_MS(CLKS_PER_MS)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctrl.run),
    .tick (tick)
  );

  ms_count_unit #(.CNT_W(PERIOD_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl.run),
    .tick   (tick),
    .period (period_q),
    .count  (count),
    .event_o(evt)
  );

  ms_status_unit u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_status (wr_status),
    .wr_run    (bus_wdata[BIT_RUN]),
    .wr_ien    (bus_wdata[BIT_IEN]),
    .wr_evt_clr(bus_wdata[BIT_EVT]),
    .event_i   (evt),
    .ctrl      (ctrl),
    .irq       (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STATUS: begin
        bus_rdata[BIT_RUN] = ctrl.run;
        bus_rdata[BIT_IEN] = ctrl.ien;
        bus_rdata[BIT_EVT] = ctrl.evt;
      end
      A_COUNT:  bus_rdata[PERIOD_W-1:0] = count;
      A_PERIOD: bus_rdata[PERIOD_W-1:0] = period_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R4: with counting stopped the count reads zero one cycle later
  a_r4_stopped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |=> (count == '0));
  // R3: the flag rises only on an event from the count unit
  a_r3_flag_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.evt) |-> $past(evt));
endmodule

// File: tb/ms_periodic_timer_test.sv
module ms_periodic_timer_test;
  localparam int L = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bwr = 1'b0;
  logic [7:0]  baddr = 8'h00;
  logic [31:0] bwd = 32'h0;
  logic [31:0] brd;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  // behavioural model state
  int m_pre = 0, m_cnt = 0, m_per = 0;
  bit m_ce = 0, m_ie = 0, m_flag = 0;

  always #5 clk = ~clk;

  ms_periodic_timer #(.CLKS_PER_MS(L)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bwr), .bus_addr(baddr),
    .bus_wdata(bwd), .bus_rdata(brd), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h08:   return {16'h0, m_ce, m_ie, m_flag, 13'h0};
      8'h34:   return 32'(m_cnt);
      8'h38:   return 32'(m_per);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit tk, ev;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_per = 0; m_ce = 0; m_ie = 0; m_flag = 0;
    end else begin
      tk = m_ce && (m_pre == L - 1);
      ev = 0;
      if (!m_ce) begin
        m_pre = 0; m_cnt = 0;
      end else begin
        m_pre = tk ? 0 : m_pre + 1;
        if (tk) begin
          if (m_per == 0) m_cnt = 0;
          else if (m_cnt + 1 >= m_per) begin m_cnt = 0; ev = 1; end
          else m_cnt = m_cnt + 1;
        end
      end
      if (bwr && baddr == 8'h08) begin
        if (bwd[13]) m_flag = 0;
        m_ce = bwd[15];
        m_ie = bwd[14];
      end
      if (ev) m_flag = 1;
      if (bwr && baddr == 8'h38) m_per = int'(bwd[9:0]);
    end
    #2;
    if (rst_n) begin
      check(irq == (m_flag && m_ie), "R7 irq", {31'h0, irq}, {31'h0, m_flag && m_ie});
      case (baddr)
        8'h08:   check(brd == model_read(baddr), "R6 status", brd, model_read(baddr));
        8'h34:   check(brd == model_read(baddr), "R3 count", brd, model_read(baddr));
        default: check(brd == model_read(baddr), "R10 read map", brd, model_read(baddr));
      endcase
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bwr = 1'b1; baddr = a; bwd = d;
    @(negedge clk);
    bwr = 1'b0; bwd = 32'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    baddr = a;
    #1 d = brd;
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    nwait(3);
    rst_n = 1'b1;
    nwait(1);

    // R1: reset values
    rd(8'h08, d); check(d == 32'h0, "R1 status", d, 32'h0);
    rd(8'h34, d); check(d == 32'h0, "R1 count", d, 32'h0);
    rd(8'h38, d); check(d == 32'h0, "R1 period", d, 32'h0);
    check(irq == 1'b0, "R1 irq", {31'h0, irq}, 32'h0);

    // R2: one count step per L cycles
    wr(8'h38, 32'd1000);
    wr(8'h08, 32'h8000);
    nwait(3 * L);
    rd(8'h34, d); check(d == 32'd3, "R2 count rate", d, 32'd3);

    // R8: count register ignores writes
    wr(8'h34, 32'h3FF);
    rd(8'h34, d); check(d == 32'd3, "R8 count read-only", d, 32'd3);

    // R4: disable clears the count
    wr(8'h08, 32'h0);
    nwait(1);
    rd(8'h34, d); check(d == 32'd0, "R4 cleared on stop", d, 32'd0);

    // R3/R4/R7: full first period after re-enable, event on exact edge
    wr(8'h38, 32'd3);
    wr(8'h08, 32'hC000);
    nwait(3 * L - 1);
    rd(8'h08, d); check(d == 32'hC000, "R4 no early event", d, 32'hC000);
    nwait(1);
    rd(8'h08, d); check(d == 32'hE000, "R3 event on period", d, 32'hE000);
    check(irq == 1'b1, "R7 irq raised", {31'h0, irq}, 32'h1);
    rd(8'h34, d); check(d == 32'd0, "R3 reload to zero", d, 32'd0);

    // R6: write-one-to-clear semantics
    wr(8'h08, 32'hC000);
    rd(8'h08, d); check(d == 32'hE000, "R6 zero keeps flag", d, 32'hE000);
    wr(8'h08, 32'hE000);
    rd(8'h08, d); check(d == 32'hC000, "R6 one clears flag", d, 32'hC000);

    // R7: flag without enable keeps irq low
    wr(8'h08, 32'h8000);
    nwait(4 * L);
    rd(8'h08, d); check(d == 32'hA000, "R7 flag set, enable off", d, 32'hA000);
    check(irq == 1'b0, "R7 irq gated", {31'h0, irq}, 32'h0);

    // R5: zero period never flags
    wr(8'h38, 32'd0);
    wr(8'h08, 32'hA000);
    nwait(10 * L);
    rd(8'h08, d); check(d == 32'h8000, "R5 no event", d, 32'h8000);
    rd(8'h34, d); check(d == 32'd0, "R5 count held", d, 32'd0);

    // R9: lowering the period below the count wraps on next tick
    wr(8'h38, 32'd1000);
    nwait(5 * L);
    wr(8'h38, 32'd2);
    nwait(L + 1);
    rd(8'h08, d); check(d[13] == 1'b1, "R9 wrap flags", d, 32'h0000A000);

    // R6: clears racing events at period 1, model compared every cycle
    wr(8'h38, 32'd1);
    wr(8'h08, 32'hE000);
    for (int i = 0; i < 12; i++) begin
      nwait(i % 4);
      wr(8'h08, 32'hE000);
    end
    baddr = 8'h08;
    nwait(3 * L);

    // R10: unmapped offset and period width
    rd(8'h00, d); check(d == 32'h0, "R10 unmapped", d, 32'h0);
    wr(8'h38, 32'hFFFF_F7FF);
    rd(8'h38, d); check(d == 32'h3FF, "R10 period width", d, 32'h3FF);
    nwait(2);

    finish_run();
  end
endmodule